// File: doc/BRIEF.md
# Power Button Hold Timer

This block watches an already-debounced power button level and turns the length of each continuous hold into requests for the power sequencer. A millisecond tick input paces two hold counters that run from the same press. The short counter asks for a boot, but only when the system reported itself off at the moment of the press. The long counter asks for a forced shutdown whatever the system state. Letting go of the button cancels whichever deadline has not yet passed. The next press starts both counts again from zero.

Two more conditions raise requests. If the lid opens while the system is off, a boot request follows at once. If the sequencer reports entry into suspend while the button is still down, the shutdown request goes out immediately and the long count no longer matters for that press. Each request leaves the block as a single-cycle pulse. The block makes at most one request of each kind per press, so a hold that started from off boots the machine, forces it off at the long deadline, and then stays quiet until the button has been released.

All inputs and outputs are plain control levels and pulses, synchronous to `clk`. No stream interface exists, so no valid/ready handshake or back-pressure applies.

Top module: `pwrbtn_hold_ctrl`

## Requirements
- R1: After reset both request outputs are low and both hold counters are cleared, so the first press counts from zero.
- R2: When a press begins with `sys_off` high, `boot_req` pulses in the clock cycle that follows the BOOT_TICKS-th tick sampled while the button stays held.
- R3: When a press begins with `sys_off` low, the button never raises `boot_req` during that press, however long it is held.
- R4: On every press, whatever `sys_off` is, `shutdown_req` pulses in the clock cycle that follows the OFF_TICKS-th tick sampled while the button stays held.
- R5: Releasing the button before a deadline cancels that request. The next press counts its ticks again from zero.
- R6: A hold that outlasts both deadlines from off gives exactly one boot pulse and then one shutdown pulse. No further button request follows until the button is released and pressed again.
- R7: A `suspend_enter` pulse while the button is held raises `shutdown_req` in the next cycle. The long deadline of that press then raises no second shutdown pulse.
- R8: A `suspend_enter` pulse while the button is released has no effect on `shutdown_req`.
- R9: A rising edge of `lid_open` while `sys_off` is high raises `boot_req` in the next cycle. A lid edge with `sys_off` low, or a lid that stays open, raises nothing.
- R10: Ticks that arrive while the button is released do not count toward either deadline. Clock cycles without a tick do not advance the counts.
- R11: Each request pulse is exactly one clock cycle wide.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick_ms | input | 1 | One-cycle pulse every millisecond |
| btn_held | input | 1 | Debounced button level, high while pressed |
| lid_open | input | 1 | Lid level, high while open |
| sys_off | input | 1 | High while the sequencer reports the system off |
| suspend_enter | input | 1 | One-cycle pulse when the sequencer enters suspend |
| boot_req | output | 1 | One-cycle request to power the system on |
| shutdown_req | output | 1 | One-cycle request to force the system off |

## Verification
The bench sweeps the hold length from zero ticks to beyond the long deadline, once with the system off and once with it on. After every tick it compares both outputs with a count kept in the bench. A design that latched `sys_off` at the wrong time would boot a running system. A counter off by one would fire a tick early or late. A counter that did not saturate would fire again, or wrap and fire a second time, on a long hold. Further cases release the button partway through a count and send ticks while it is up, to catch a counter that keeps its value or counts while released. Suspend pulses are sent both with the button held and released. The bench then holds past the long deadline after a suspend-triggered shutdown to expose a double request. Lid edges are driven against both `sys_off` levels, and the lid is also held open, to catch a design that acts on the level rather than the edge.

// File: rtl/pbh_pkg.sv
package pbh_pkg;

  // Width needed to hold a count of 0..limit.
  function automatic int unsigned cnt_width(input int unsigned limit);
    return (limit < 2) ? 1 : $clog2(limit + 1);
  endfunction

  // Indices of the level inputs that get a rising-edge detector.
  localparam int unsigned EDGE_BTN = 0;
  localparam int unsigned EDGE_LID = 1;
  localparam int unsigned EDGE_NUM = 2;

endpackage

// File: rtl/pbh_rise.sv
module pbh_rise (
  input  logic clk,
  input  logic rst_n,
  input  logic level_i,
  output logic rise_o
);
  logic level_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) level_q <= 1'b0;
    else        level_q <= level_i;
  end

  assign rise_o = level_i & ~level_q;

  // R9
  rise_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rise_o |=> !rise_o);
endmodule

// File: rtl/pbh_hold_timer.sv
module pbh_hold_timer #(
  parameter int unsigned LIMIT = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic held_i,
  input  logic tick_i,
  output logic hit_o
);
  import pbh_pkg::*;

  localparam int unsigned W = cnt_width(LIMIT);
  localparam logic [W-1:0] CNT_TOP  = W'(LIMIT);
  localparam logic [W-1:0] CNT_LAST = W'(LIMIT - 1);

  logic [W-1:0] cnt_q;

  // Cleared whenever the button is up; advanced once per tick while held;
  // parks at the deadline so a long hold cannot fire a second time.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                            cnt_q <= '0;
    else if (!held_i)                      cnt_q <= '0;
    else if (tick_i && cnt_q != CNT_TOP)   cnt_q <= cnt_q + 1'b1;
  end

  assign hit_o = held_i & tick_i & (cnt_q == CNT_LAST);

  // R6
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_TOP);

  // R10
  cnt_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (held_i && !tick_i) |=> $stable(cnt_q) || !$past(held_i));

  // R5
  cnt_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !held_i |=> cnt_q == '0);
endmodule

// File: rtl/pbh_req_gate.sv
module pbh_req_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic btn_held,
  input  logic press_rise,
  input  logic lid_rise,
  input  logic sys_off,
  input  logic suspend_enter,
  input  logic boot_hit,
  input  logic off_hit,
  output logic boot_req,
  output logic shutdown_req
);
  logic boot_arm_q;
  logic shut_done_q;
  logic arm_now;
  logic boot_fire;
  logic shut_fire;

  // Boot eligibility is taken from sys_off at the press edge.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          boot_arm_q <= 1'b0;
    else if (press_rise) boot_arm_q <= sys_off;
    else if (!btn_held)  boot_arm_q <= 1'b0;
  end

  assign arm_now   = press_rise ? sys_off : boot_arm_q;
  assign boot_fire = (boot_hit & arm_now) | (lid_rise & sys_off);
  assign shut_fire = btn_held & ~shut_done_q & (off_hit | suspend_enter);

  // One shutdown per press, re-enabled only by a release.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         shut_done_q <= 1'b0;
    else if (!btn_held) shut_done_q <= 1'b0;
    else if (shut_fire) shut_done_q <= 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      boot_req     <= 1'b0;
      shutdown_req <= 1'b0;
    end else begin
      boot_req     <= boot_fire;
      shutdown_req <= shut_fire;
    end
  end

  // R11
  shut_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    shutdown_req |=> !shutdown_req);

  // R11
  boot_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    boot_req |=> !boot_req);

  // R8
  shut_needs_btn_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !btn_held |=> !shutdown_req);

  // R7
  shut_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (shut_done_q && btn_held) |=> !shutdown_req);

  // R3
  boot_needs_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (btn_held && !arm_now && !lid_rise) |=> !boot_req);
endmodule

// File: rtl/pwrbtn_hold_ctrl.sv
module pwrbtn_hold_ctrl #(
  parameter int unsigned BOOT_TICKS = 10,
  parameter int unsigned OFF_TICKS  = 8000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_ms,
  input  logic btn_held,
  input  logic lid_open,
  input  logic sys_off,
  input  logic suspend_enter,
  output logic boot_req,
  output logic shutdown_req
);
  import pbh_pkg::*;

  localparam int unsigned NTIMER = 2;

  logic [EDGE_NUM-1:0] lvl;
  logic [EDGE_NUM-1:0] rise;
  logic [NTIMER-1:0]   hit;

  assign lvl[EDGE_BTN] = btn_held;
  assign lvl[EDGE_LID] = lid_open;

  for (genvar e = 0; e < EDGE_NUM; e++) begin : g_edge
    pbh_rise u_rise (
      .clk     (clk),
      .rst_n   (rst_n),
      .level_i (lvl[e]),
      .rise_o  (rise[e])
    );
  end

  // Timer 0 is the short boot hold, timer 1 the long forced-off hold.
  for (genvar t = 0; t < NTIMER; t++) begin : g_timer
    localparam int unsigned LIM = (t == 0) ? BOOT_TICKS : OFF_TICKS;
    pbh_hold_timer #(.LIMIT(LIM)) u_timer (
      .clk    (clk),
      .rst_n  (rst_n),
      .held_i (btn_held),
      .tick_i (tick_ms),
      .hit_o  (hit[t])
    );
  end

  pbh_req_gate u_gate (
    .clk           (clk),
    .rst_n         (rst_n),
    .btn_held      (btn_held),
    .press_rise    (rise[EDGE_BTN]),
    .lid_rise      (rise[EDGE_LID]),
    .sys_off       (sys_off),
    .suspend_enter (suspend_enter),
    .boot_hit      (hit[0]),
    .off_hit       (hit[1]),
    .boot_req      (boot_req),
    .shutdown_req  (shutdown_req)
  );

  // R9
  lid_level_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(lid_open) && !btn_held && !$past(btn_held)) |=> !boot_req);

  // R4
  shut_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(shutdown_req) |-> $past(btn_held));
endmodule

// File: tb/tb_pwrbtn_hold_ctrl.sv
module tb_pwrbtn_hold_ctrl;
  localparam int unsigned BOOT = 3;
  localparam int unsigned OFF  = 7;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick_ms = 1'b0, btn_held = 1'b0, lid_open = 1'b0;
  logic sys_off = 1'b0, suspend_enter = 1'b0;
  logic boot_req, shutdown_req;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  pwrbtn_hold_ctrl #(.BOOT_TICKS(BOOT), .OFF_TICKS(OFF)) dut (
    .clk(clk), .rst_n(rst_n), .tick_ms(tick_ms), .btn_held(btn_held),
    .lid_open(lid_open), .sys_off(sys_off), .suspend_enter(suspend_enter),
    .boot_req(boot_req), .shutdown_req(shutdown_req)
  );

  task automatic chk(input string req, input logic eb, input logic es);
    checks++;
    if (boot_req !== eb || shutdown_req !== es) begin
      errors++;
      $display("FAIL %s: boot=%b shut=%b expected boot=%b shut=%b",
               req, boot_req, shutdown_req, eb, es);
    end
  endtask

  task automatic cyc();
    @(negedge clk);
  endtask

  // One tick cycle then one quiet cycle; checks both.
  task automatic tick_chk(input string req, input logic eb, input logic es);
    tick_ms = 1'b1; cyc(); tick_ms = 1'b0;
    chk(req, eb, es);
    cyc();
    chk("R11", 1'b0, 1'b0);
  endtask

  task automatic press(input logic off);
    sys_off = off; btn_held = 1'b1; cyc();
    chk("R10", 1'b0, 1'b0);
  endtask

  task automatic release_btn();
    btn_held = 1'b0; cyc(); cyc();
    chk("R5", 1'b0, 1'b0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not end, actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) cyc();
    chk("R1", 1'b0, 1'b0);
    rst_n = 1'b1;
    cyc();
    chk("R1", 1'b0, 1'b0);

    // Sweep of hold lengths with the system off and on (R2 R3 R4 R6).
    for (int so = 0; so < 2; so++) begin
      for (int h = 0; h <= OFF + 3; h++) begin
        press(so[0]);
        for (int n = 1; n <= h; n++)
          tick_chk(so[0] ? "R2/R6" : "R3/R4",
                   so[0] && n == BOOT, n == OFF);
        release_btn();
      end
    end

    // Ticks while released do not count; a fresh press restarts (R10 R5).
    press(1'b0);
    for (int n = 1; n <= OFF - 2; n++) tick_chk("R5", 1'b0, 1'b0);
    btn_held = 1'b0; cyc();
    for (int n = 0; n < 4; n++) tick_chk("R10", 1'b0, 1'b0);
    press(1'b0);
    for (int n = 1; n <= OFF; n++) tick_chk("R5", 1'b0, n == OFF);
    release_btn();

    // Cycles without a tick do not advance (R10).
    press(1'b1);
    for (int n = 0; n < 20; n++) begin cyc(); chk("R10", 1'b0, 1'b0); end
    for (int n = 1; n <= BOOT; n++) tick_chk("R10", n == BOOT, 1'b0);
    release_btn();

    // Suspend while held: immediate, then no timer shutdown (R7).
    for (int k = 0; k <= OFF + 1; k++) begin
      press(1'b0);
      for (int n = 1; n <= k; n++) tick_chk("R7", 1'b0, n == OFF);
      suspend_enter = 1'b1; cyc(); suspend_enter = 1'b0;
      chk("R7", 1'b0, k < OFF);
      cyc();
      chk("R11", 1'b0, 1'b0);
      for (int n = k + 1; n <= OFF + 2; n++) tick_chk("R7", 1'b0, 1'b0);
      release_btn();
    end

    // Suspend while released is ignored (R8).
    suspend_enter = 1'b1; cyc(); suspend_enter = 1'b0;
    chk("R8", 1'b0, 1'b0);
    cyc();
    chk("R8", 1'b0, 1'b0);

    // Lid edges (R9).
    sys_off = 1'b1; lid_open = 1'b1; cyc();
    chk("R9", 1'b1, 1'b0);
    for (int n = 0; n < 5; n++) begin cyc(); chk("R9", 1'b0, 1'b0); end
    lid_open = 1'b0; cyc(); chk("R9", 1'b0, 1'b0);
    sys_off = 1'b0; lid_open = 1'b1; cyc();
    chk("R9", 1'b0, 1'b0);
    lid_open = 1'b0; cyc();
    sys_off = 1'b1; cyc();
    chk("R9", 1'b0, 1'b0);
    lid_open = 1'b1; cyc();
    chk("R9", 1'b1, 1'b0);
    lid_open = 1'b0; cyc();

    // Reset mid-hold clears counts (R1).
    press(1'b1);
    tick_chk("R1", 1'b0, 1'b0);
    tick_chk("R1", 1'b0, 1'b0);
    rst_n = 1'b0; cyc(); chk("R1", 1'b0, 1'b0);
    btn_held = 1'b0; rst_n = 1'b1; cyc();
    press(1'b1);
    for (int n = 1; n <= BOOT; n++) tick_chk("R1", n == BOOT, 1'b0);
    release_btn();

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule